// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, A and B, and moves data between them in either direction. The data path is split into independent slices of eight bits (two by default). Each slice has its own pair of capture clocks, source selects and output enables. Tying the controls of all slices together gives one wide path. Every bus line is modelled as three signals: the value the block sees on the line, a flag that says another agent is driving it, and the block's own output with its enable.

Each slice holds two storage registers. One takes a snapshot of the A bus and the other of the B bus. Each snapshot is taken on a rising edge of its own direction clock. The direction clocks are treated as asynchronous: they are synchronised to the system clock and edge detected. A capture happens whatever the selects and enables are set to. For each direction, a select picks what is driven onto the far bus: the live value of the near bus (select low) or the stored snapshot (select high). The A-to-B enable is active high. The B-to-A enable is active low. When no agent drives a line, a keeper holds its last value. This means live transfer with both directions enabled forms a loop that holds both buses at their current value. All outputs come from registers, so changing a select moves the output from the old source to the new one in a single step.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every output enable is 0 and every output bit is 0. Both storage registers and both keepers of every slice start at 0.
- R2: After a rising edge on a slice's A-capture clock, that slice's A register holds the A-bus value seen three system clocks after the edge. This is the externally driven value when the driven flag is set, otherwise the block's own driven value or the keeper. The capture happens for any setting of the selects and enables.
- R3: The B register of a slice captures the B-bus value in the same way on a rising edge of the slice's B-capture clock.
- R4: One system clock after `en_ab` of a slice is 1, every `b_oe` bit of that slice is 1. One clock after `en_ba_n` of a slice is 0, every `a_oe` bit of that slice is 1.
- R5: With source select 0 (live), the driven output of a slice carries the opposite bus value sampled in the previous system clock.
- R6: With source select 1 (stored), the driven output of a slice carries the register of the opposite bus: `b_out` shows the A register and `a_out` shows the B register.
- R7: With `en_ab` at 0 and `en_ba_n` at 1, one clock later both output enables of that slice are 0 and the two buses are isolated.
- R8: With both selects 0, both directions enabled and no external driver on either bus, both buses hold their common value once it has been set.
- R9: A line with no external driver and no drive from the block keeps the last value it carried. A live transfer from that line therefore keeps passing that value.
- R10: The control inputs of one slice have no effect on the outputs or stored state of any other slice.
- R11: While A is passed live onto B, rising edges on both capture clocks in the same cycle load the same A value into both registers of the slice.
- R12: When a select changes, the output moves to the new source's value in the next system clock. No other value appears in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Value driven onto the A lines by other agents |
| a_drv | input | 16 | Per line: 1 when another agent drives the A line |
| a_out | output | 16 | Value the block drives onto A |
| a_oe | output | 16 | Per line enable for `a_out` |
| b_in | input | 16 | Value driven onto the B lines by other agents |
| b_drv | input | 16 | Per line: 1 when another agent drives the B line |
| b_out | output | 16 | Value the block drives onto B |
| b_oe | output | 16 | Per line enable for `b_out` |
| ld_a_clk | input | 2 | Per slice asynchronous capture clock for the A register |
| ld_b_clk | input | 2 | Per slice asynchronous capture clock for the B register |
| src_ab | input | 2 | Per slice source for B: 0 live A, 1 stored A |
| src_ba | input | 2 | Per slice source for A: 0 live B, 1 stored B |
| en_ab | input | 2 | Per slice A-to-B enable, active high |
| en_ba_n | input | 2 | Per slice B-to-A enable, active low |

## Verification
The assertions assume that the controls and the bus data are synchronous to the system clock and stay stable for at least one clock. They also assume that the capture clocks stay at each level for at least two system clocks, so the synchroniser never misses an edge. The bench changes every input only on the falling edge of the system clock. It holds each capture clock level for two or more cycles, in the directed tests and in the random phase alike. The loop-hold property is claimed only when both buses already agree. The bench enters the loop mode by first driving A from outside and releasing it only after B has followed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    function automatic logic [63:0] resolve_line(
        input logic [63:0] ext_val,
        input logic [63:0] ext_drv,
        input logic [63:0] own_val,
        input logic        own_oe,
        input logic [63:0] held_val
    );
        logic [63:0] internal;
        internal = own_oe ? own_val : held_val;
        return (ext_drv & ext_val) | (~ext_drv & internal);
    endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.chain[LAST] & ~st_q.prev;

endmodule

// File: rtl/xcvr_slice.sv
module xcvr_slice
    import xcvr_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  logic         ld_a_clk,
    input  logic         ld_b_clk,
    input  logic         src_ab,
    input  logic         src_ba,
    input  logic         en_ab,
    input  logic         en_ba_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    localparam int PADW = 64 - W;

    typedef struct packed {
        logic [W-1:0] snap_a;
        logic [W-1:0] snap_b;
        logic [W-1:0] hold_a;
        logic [W-1:0] hold_b;
        logic [W-1:0] drv_a;
        logic [W-1:0] drv_b;
        logic         oe_a;
        logic         oe_b;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      rise_a, rise_b;
    logic [W-1:0] view_a, view_b;
    logic [63:0]  view_a_w, view_b_w;

    xcvr_edge_sync #(.STAGES(SYNC_STAGES)) sync_a_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ld_a_clk),
        .rise_o  (rise_a)
    );

    xcvr_edge_sync #(.STAGES(SYNC_STAGES)) sync_b_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ld_b_clk),
        .rise_o  (rise_b)
    );

    always_comb begin
        view_a_w = resolve_line({{PADW{1'b0}}, a_in}, {{PADW{1'b0}}, a_drv},
                                {{PADW{1'b0}}, st_q.drv_a}, st_q.oe_a,
                                {{PADW{1'b0}}, st_q.hold_a});
        view_b_w = resolve_line({{PADW{1'b0}}, b_in}, {{PADW{1'b0}}, b_drv},
                                {{PADW{1'b0}}, st_q.drv_b}, st_q.oe_b,
                                {{PADW{1'b0}}, st_q.hold_b});
        view_a = view_a_w[W-1:0];
        view_b = view_b_w[W-1:0];
    end

    always_comb begin
        st_d = st_q;
        if (rise_a) begin
            st_d.snap_a = view_a;
        end
        if (rise_b) begin
            st_d.snap_b = view_b;
        end
        st_d.hold_a = view_a;
        st_d.hold_b = view_b;
        st_d.drv_b  = (src_e'(src_ab) == SRC_STORED) ? st_q.snap_a : view_a;
        st_d.drv_a  = (src_e'(src_ba) == SRC_STORED) ? st_q.snap_b : view_b;
        st_d.oe_b   = en_ab;
        st_d.oe_a   = ~en_ba_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out = st_q.drv_a;
    assign a_oe  = st_q.oe_a;
    assign b_out = st_q.drv_b;
    assign b_oe  = st_q.oe_b;

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
    parameter int HALF_W      = 8,
    parameter int NUM_HALVES  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int BUS_W      = HALF_W * NUM_HALVES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BUS_W-1:0]      a_in,
    input  logic [BUS_W-1:0]      a_drv,
    output logic [BUS_W-1:0]      a_out,
    output logic [BUS_W-1:0]      a_oe,
    input  logic [BUS_W-1:0]      b_in,
    input  logic [BUS_W-1:0]      b_drv,
    output logic [BUS_W-1:0]      b_out,
    output logic [BUS_W-1:0]      b_oe,
    input  logic [NUM_HALVES-1:0] ld_a_clk,
    input  logic [NUM_HALVES-1:0] ld_b_clk,
    input  logic [NUM_HALVES-1:0] src_ab,
    input  logic [NUM_HALVES-1:0] src_ba,
    input  logic [NUM_HALVES-1:0] en_ab,
    input  logic [NUM_HALVES-1:0] en_ba_n
);

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_slice
        logic a_oe_s, b_oe_s;

        xcvr_slice #(
            .W           (HALF_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) slice_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_in     (a_in [g*HALF_W +: HALF_W]),
            .a_drv    (a_drv[g*HALF_W +: HALF_W]),
            .b_in     (b_in [g*HALF_W +: HALF_W]),
            .b_drv    (b_drv[g*HALF_W +: HALF_W]),
            .ld_a_clk (ld_a_clk[g]),
            .ld_b_clk (ld_b_clk[g]),
            .src_ab   (src_ab[g]),
            .src_ba   (src_ba[g]),
            .en_ab    (en_ab[g]),
            .en_ba_n  (en_ba_n[g]),
            .a_out    (a_out[g*HALF_W +: HALF_W]),
            .a_oe     (a_oe_s),
            .b_out    (b_out[g*HALF_W +: HALF_W]),
            .b_oe     (b_oe_s)
        );

        assign a_oe[g*HALF_W +: HALF_W] = {HALF_W{a_oe_s}};
        assign b_oe[g*HALF_W +: HALF_W] = {HALF_W{b_oe_s}};
    end

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
    parameter int HALF_W      = 8,
    parameter int NUM_HALVES  = 2,
    parameter int SYNC_STAGES = 2,
    localparam int BUS_W      = HALF_W * NUM_HALVES
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BUS_W-1:0]      a_in,
    input logic [BUS_W-1:0]      a_drv,
    input logic [BUS_W-1:0]      a_out,
    input logic [BUS_W-1:0]      a_oe,
    input logic [BUS_W-1:0]      b_in,
    input logic [BUS_W-1:0]      b_drv,
    input logic [BUS_W-1:0]      b_out,
    input logic [BUS_W-1:0]      b_oe,
    input logic [NUM_HALVES-1:0] ld_a_clk,
    input logic [NUM_HALVES-1:0] ld_b_clk,
    input logic [NUM_HALVES-1:0] src_ab,
    input logic [NUM_HALVES-1:0] src_ba,
    input logic [NUM_HALVES-1:0] en_ab,
    input logic [NUM_HALVES-1:0] en_ba_n
);
    logic rst_dly;

    always_ff @(posedge clk) begin
        rst_dly <= rst_n;
    end

    always @(posedge clk) begin
        if (rst_n && !rst_dly) begin
            AST_RESET_QUIET: assert (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0); // R1
        end
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_chk
        AST_AB_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            en_ab[g] |=> (&b_oe[g*HALF_W +: HALF_W])); // R4

        AST_BA_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !en_ba_n[g] |=> (&a_oe[g*HALF_W +: HALF_W])); // R4

        AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_ab[g] && en_ba_n[g]) |=>
            (b_oe[g*HALF_W +: HALF_W] == '0 && a_oe[g*HALF_W +: HALF_W] == '0)); // R7

        AST_LIVE_AB: assert property (@(posedge clk) disable iff (!rst_n)
            (en_ab[g] && !src_ab[g] && (&a_drv[g*HALF_W +: HALF_W])) |=>
            (b_out[g*HALF_W +: HALF_W] == $past(a_in[g*HALF_W +: HALF_W]))); // R5

        AST_LIVE_BA: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_ba_n[g] && !src_ba[g] && (&b_drv[g*HALF_W +: HALF_W])) |=>
            (a_out[g*HALF_W +: HALF_W] == $past(b_in[g*HALF_W +: HALF_W]))); // R5

        AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (en_ab[g] && !en_ba_n[g] && !src_ab[g] && !src_ba[g]
             && a_drv[g*HALF_W +: HALF_W] == '0 && b_drv[g*HALF_W +: HALF_W] == '0
             && (&a_oe[g*HALF_W +: HALF_W]) && (&b_oe[g*HALF_W +: HALF_W])
             && a_out[g*HALF_W +: HALF_W] == b_out[g*HALF_W +: HALF_W]) |=>
            ($stable(a_out[g*HALF_W +: HALF_W]) && $stable(b_out[g*HALF_W +: HALF_W]))); // R8
    end

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(
    .HALF_W      (HALF_W),
    .NUM_HALVES  (NUM_HALVES),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (.*);

// File: tb/bus_xcvr_reg_tb_top.sv
module bus_xcvr_reg_tb_top;
    localparam int H  = 8;
    localparam int NH = 2;
    localparam int W  = H * NH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0]  a_in = '0, a_drv = '0, b_in = '0, b_drv = '0;
    logic [W-1:0]  a_out, a_oe, b_out, b_oe;
    logic [NH-1:0] ld_a_clk = '0, ld_b_clk = '0, src_ab = '0, src_ba = '0;
    logic [NH-1:0] en_ab = '0, en_ba_n = '1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    bus_xcvr_reg #(.HALF_W(H), .NUM_HALVES(NH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
        .ld_a_clk(ld_a_clk), .ld_b_clk(ld_b_clk),
        .src_ab(src_ab), .src_ba(src_ba), .en_ab(en_ab), .en_ba_n(en_ba_n)
    );

    // Behavioural reference: per slice state kept in integer-indexed arrays
    logic [H-1:0] m_rega [NH], m_regb [NH], m_keepa [NH], m_keepb [NH];
    logic [H-1:0] m_aout [NH], m_bout [NH];
    logic         m_aoe [NH], m_boe [NH];
    int           m_ca [NH][3], m_cb [NH][3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int h = 0; h < NH; h++) begin
                m_rega[h] = '0; m_regb[h] = '0; m_keepa[h] = '0; m_keepb[h] = '0;
                m_aout[h] = '0; m_bout[h] = '0; m_aoe[h] = 1'b0; m_boe[h] = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    m_ca[h][k] = 0; m_cb[h][k] = 0;
                end
            end
        end else begin
            for (int h = 0; h < NH; h++) begin
                logic [H-1:0] seen_a, seen_b;
                bit edge_a, edge_b;
                for (int i = 0; i < H; i++) begin
                    if (a_drv[h*H+i]) seen_a[i] = a_in[h*H+i];
                    else if (m_aoe[h]) seen_a[i] = m_aout[h][i];
                    else seen_a[i] = m_keepa[h][i];
                    if (b_drv[h*H+i]) seen_b[i] = b_in[h*H+i];
                    else if (m_boe[h]) seen_b[i] = m_bout[h][i];
                    else seen_b[i] = m_keepb[h][i];
                end
                edge_a = (m_ca[h][1] == 1) && (m_ca[h][2] == 0);
                edge_b = (m_cb[h][1] == 1) && (m_cb[h][2] == 0);
                m_ca[h][2] = m_ca[h][1]; m_ca[h][1] = m_ca[h][0]; m_ca[h][0] = int'(ld_a_clk[h]);
                m_cb[h][2] = m_cb[h][1]; m_cb[h][1] = m_cb[h][0]; m_cb[h][0] = int'(ld_b_clk[h]);
                m_bout[h] = src_ab[h] ? m_rega[h] : seen_a;
                m_aout[h] = src_ba[h] ? m_regb[h] : seen_b;
                m_boe[h]  = en_ab[h];
                m_aoe[h]  = !en_ba_n[h];
                if (edge_a) m_rega[h] = seen_a;
                if (edge_b) m_regb[h] = seen_b;
                m_keepa[h] = seen_a;
                m_keepb[h] = seen_b;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the reference on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int h = 0; h < NH; h++) begin
                check({phase, " oe_b"}, {31'b0, b_oe[h*H]}, {31'b0, m_boe[h]});
                check({phase, " oe_a"}, {31'b0, a_oe[h*H]}, {31'b0, m_aoe[h]});
                if (m_boe[h]) check({phase, " b_out"}, {24'b0, b_out[h*H +: H]}, {24'b0, m_bout[h]});
                if (m_aoe[h]) check({phase, " a_out"}, {24'b0, a_out[h*H +: H]}, {24'b0, m_aout[h]});
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit on_a, input bit on_b, input int h);
        if (on_a) ld_a_clk[h] = 1'b1;
        if (on_b) ld_b_clk[h] = 1'b1;
        cyc(3);
        ld_a_clk[h] = 1'b0;
        ld_b_clk[h] = 1'b0;
        cyc(3);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [H-1:0] keep_hi;
        cyc(3);
        // R1: reset state
        check("R1 reset a_oe", {16'b0, a_oe}, 32'h0);
        check("R1 reset b_oe", {16'b0, b_oe}, 32'h0);
        check("R1 reset outs", {a_out, b_out}, 32'h0);
        rst_n = 1'b1;
        cyc(2);
        // R1: registers start at zero, shown through stored source
        en_ab = 2'b11; src_ab = 2'b11;
        cyc(2);
        check("R1 A regs zero", {16'b0, b_out}, 32'h0);
        en_ab = 2'b00; src_ab = 2'b00;

        // R7: isolation
        phase = "R7";
        cyc(2);
        check("R7 isolated", {a_oe, b_oe}, 32'h0);

        // R4 R5: live A to B on slice 0
        phase = "R5";
        en_ab[0] = 1'b1; a_drv[7:0] = 8'hFF; a_in[7:0] = 8'h5A;
        cyc(2);
        check("R4 b_oe slice0", {16'b0, b_oe}, 32'h00FF);
        check("R5 live A->B", {24'b0, b_out[7:0]}, 32'h5A);

        // R5: live B to A on slice 1
        en_ba_n[1] = 1'b0; b_drv[15:8] = 8'hFF; b_in[15:8] = 8'hC3;
        cyc(2);
        check("R4 a_oe slice1", {16'b0, a_oe}, 32'hFF00);
        check("R5 live B->A", {24'b0, a_out[15:8]}, 32'hC3);

        // R9: release A driver on slice 0; keeper holds 5A
        phase = "R9";
        a_drv[7:0] = 8'h00; a_in[7:0] = 8'h00;
        cyc(4);
        check("R9 keeper holds A", {24'b0, b_out[7:0]}, 32'h5A);

        // R2 R6: capture A with outputs disabled, then show stored data
        phase = "R2";
        en_ab[0] = 1'b0; src_ab[0] = 1'b1;
        a_drv[7:0] = 8'hFF; a_in[7:0] = 8'h3C;
        keep_hi = a_out[15:8];
        pulse(1'b1, 1'b0, 0);
        a_in[7:0] = 8'h11;
        en_ab[0] = 1'b1;
        cyc(2);
        check("R2 A reg captured", {24'b0, b_out[7:0]}, 32'h3C);
        check("R6 stored A->B", {24'b0, b_out[7:0]}, 32'h3C);
        check("R10 slice1 untouched", {24'b0, a_out[15:8]}, {24'b0, keep_hi});

        // R12: select switch takes one clock, no intermediate value
        phase = "R12";
        src_ab[0] = 1'b0;
        cyc(1);
        check("R12 switch to live", {24'b0, b_out[7:0]}, 32'h11);
        src_ab[0] = 1'b1;
        cyc(1);
        check("R12 switch to stored", {24'b0, b_out[7:0]}, 32'h3C);

        // R3: capture B on slice 1 while select is live, then show stored
        phase = "R3";
        b_in[15:8] = 8'h9E;
        pulse(1'b0, 1'b1, 1);
        b_in[15:8] = 8'h21;
        src_ba[1] = 1'b1;
        cyc(2);
        check("R3 B reg to A", {24'b0, a_out[15:8]}, 32'h9E);

        // R8: loop latch on slice 1
        phase = "R8";
        src_ba[1] = 1'b0; b_drv[15:8] = 8'h00;
        en_ab[1] = 1'b1; en_ba_n[1] = 1'b0; src_ab[1] = 1'b0;
        a_drv[15:8] = 8'hFF; a_in[15:8] = 8'hE7;
        cyc(4);
        a_drv[15:8] = 8'h00; a_in[15:8] = 8'h00;
        cyc(6);
        check("R8 loop A", {24'b0, a_out[15:8]}, 32'hE7);
        check("R8 loop B", {24'b0, b_out[15:8]}, 32'hE7);

        // R11: one clock loads A into both registers of slice 0
        phase = "R11";
        src_ab[0] = 1'b0; en_ab[0] = 1'b1;
        a_drv[7:0] = 8'hFF; a_in[7:0] = 8'h4B; b_drv[7:0] = 8'h00;
        cyc(2);
        pulse(1'b1, 1'b1, 0);
        a_in[7:0] = 8'h00; src_ab[0] = 1'b1;
        cyc(2);
        check("R11 A reg", {24'b0, b_out[7:0]}, 32'h4B);
        en_ab[0] = 1'b0; en_ba_n[0] = 1'b0; src_ba[0] = 1'b1; a_drv[7:0] = 8'h00;
        cyc(2);
        check("R11 B reg", {24'b0, a_out[7:0]}, 32'h4B);
        check("R8 slice1 loop unaffected R10", {24'b0, b_out[15:8]}, 32'hE7);

        // R10: random traffic, each slice controlled independently
        phase = "R10";
        for (int t = 0; t < 3000; t++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            a_drv = 16'($urandom); b_drv = 16'($urandom);
            if (t % 4 == 0) begin
                src_ab = 2'($urandom); src_ba = 2'($urandom);
                en_ab = 2'($urandom); en_ba_n = 2'($urandom);
            end
            if (t % 3 == 0) begin
                ld_a_clk = 2'($urandom); ld_b_clk = 2'($urandom);
            end
            cyc(1);
        end
        cyc(2);
        finish_run();
    end

endmodule